// File: doc/BRIEF.md
# Banked Mask Interrupt Controller

This block gathers 96 level-sensitive interrupt sources into two processor lines: a normal interrupt line and a fast interrupt line. The sources sit in three mask banks of 32. Source number `s` lives in bank `s / 32`, at bit `s % 32`. A mask bit of 1 blocks its source. Out of reset every source is masked and steered to the normal line. A per-source steering register moves a source onto the fast line instead.

For the normal line, a fixed-priority arbiter picks the lowest-numbered source that is pending, unmasked and steered to the normal line. The controller latches that winner and asserts `irq_o`. The latched vector then stays fixed, whatever the sources or masks do, until software writes the release bit in the control register. After a release the line is low for at least one cycle, and then arbitration runs again. The fast line is a registered OR of all pending, unmasked sources that are steered to it.

Software reaches the registers through a simple word-addressed bus. The address and write enable take effect at the clock edge. Read data is combinational from the address.

Top module: `banked_intc`

## Requirements
- R1: After reset, all three mask banks read 0xFFFFFFFF, every steering register reads 0, `irq_o` and `fiq_o` are 0, and the active register at address 0x01 reads 0x7F.
- R2: A write to address 0x10+b (b = 0..2) replaces mask bank b with the write data, and a read of that address returns the current mask bank.
- R3: A write to address 0x14+b sets the mask bits of bank b where the data has ones. Bits written as zero are left unchanged.
- R4: A write to address 0x18+b clears the mask bits of bank b where the data has ones. Bits written as zero are left unchanged.
- R5: A pending source `s` whose mask bit (bank s/32, bit s%32) is 0 and whose steering bit is 0 is latched at the next clock edge while no vector is held. After that edge, `irq_o` is 1 and address 0x01 reads bit 7 = 1 and bits [6:0] = s.
- R6: When several sources qualify in the same cycle, the lowest-numbered one is latched.
- R7: While a vector is held, `irq_o` stays 1 and the vector stays unchanged, even if the source drops, the source is masked or another source is raised. This lasts until a release write.
- R8: A write to address 0x00 with data bit 0 set releases the held vector. In the cycle after that write, `irq_o` is 0 and address 0x01 reads 0x7F. Arbitration resumes at the following edge.
- R9: Bit 0 of the steering register at address 0x80+s routes source s to the fast line. Such a source never becomes the normal-line vector. `fiq_o` is 1 in the cycle after any fast-steered source is pending and unmasked.
- R10: While no vector is held, address 0x01 reads 0x7F: the valid flag in bit 7 is clear and the vector field holds the reserved value 0x7F.
- R11: A masked source never wins arbitration and never drives `fiq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 96 | Level-sensitive interrupt sources |
| addr_i | input | 8 | Register word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Normal interrupt line (a vector is held) |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
Each internal state of the block shows up at the ports within a cycle.
- A mask bit or steering bit that is corrupted shows up at once on a readback of its address. It also shows up one edge later as a wrong winner on `irq_o`, a missing winner, or a spurious level on `fiq_o`.
- A held vector that drifts, or that fails to clear on release, is visible on the next read of address 0x01. It is also visible as `irq_o` failing to drop in the cycle right after the release write.
- A bench model that steps cycle by cycle compares every output and every read against these rules.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_BANKS = 3;
  localparam int BANK_W    = 32;
  localparam int NUM_SRC   = NUM_BANKS * BANK_W;
  localparam int VEC_W     = $clog2(NUM_SRC + 1);
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_ACTIVE = 8'h01;
  localparam logic [ADDR_W-1:0] A_MASK   = 8'h10;
  localparam logic [ADDR_W-1:0] A_MSET   = 8'h14;
  localparam logic [ADDR_W-1:0] A_MCLR   = 8'h18;
  localparam logic [ADDR_W-1:0] A_STEER  = 8'h80;

  localparam logic [VEC_W-1:0] VEC_NONE = '1;

  typedef struct packed {
    logic             valid;
    logic [VEC_W-1:0] vec;
  } irq_sel_t;
endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '1;
    else if (wr_i)  mask_q <= wdata_i;
    else if (set_i) mask_q <= mask_q | wdata_i;
    else if (clr_i) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N     = 96,
  parameter int IDX_W = 7
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest set index is written last and wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_irq_latch.sv
module intc_irq_latch
  import intc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             found_i,
  input  logic [VEC_W-1:0] idx_i,
  output irq_sel_t         sel_o
);
  irq_sel_t sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '{valid: 1'b0, vec: VEC_NONE};
    end else if (ack_i) begin
      sel_q <= '{valid: 1'b0, vec: VEC_NONE};
    end else if (!sel_q.valid && found_i) begin
      sel_q <= '{valid: 1'b1, vec: idx_i};
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import intc_pkg::*;
#(
  parameter int BANKS = NUM_BANKS,
  parameter int BW    = BANK_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [BANKS*BW-1:0]      src_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     we_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     irq_o,
  output logic                     fiq_o
);
  localparam int NS = BANKS * BW;
  localparam int STEER_END = int'(A_STEER) + NS;

  logic [NS-1:0]   mask_all;
  logic [NS-1:0]   steer_q;
  logic [NS-1:0]   irq_req;
  logic [NS-1:0]   fiq_req;
  logic            irq_found;
  logic [VEC_W-1:0] irq_idx;
  logic [VEC_W-1:0] irq_vec;
  irq_sel_t        sel;
  logic            ack;
  logic            steer_hit;
  logic [ADDR_W-1:0] steer_idx;
  logic            fiq_q;

  assign ack       = we_i && (addr_i == A_CTRL) && wdata_i[0];
  assign steer_idx = addr_i - A_STEER;
  assign steer_hit = (int'(addr_i) >= int'(A_STEER)) && (int'(addr_i) < STEER_END);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit_wr, hit_set, hit_clr;
    assign hit_wr  = we_i && (addr_i == A_MASK + ADDR_W'(b));
    assign hit_set = we_i && (addr_i == A_MSET + ADDR_W'(b));
    assign hit_clr = we_i && (addr_i == A_MCLR + ADDR_W'(b));

    intc_mask_bank #(.W(BW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (hit_wr),
      .set_i   (hit_set),
      .clr_i   (hit_clr),
      .wdata_i (wdata_i[BW-1:0]),
      .mask_o  (mask_all[b*BW +: BW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steer_q <= '0;
    end else if (we_i && steer_hit) begin
      steer_q[steer_idx] <= wdata_i[0];
    end
  end

  assign irq_req = src_i & ~mask_all & ~steer_q;
  assign fiq_req = src_i & ~mask_all &  steer_q;

  intc_prio_enc #(.N(NS), .IDX_W(VEC_W)) u_prio (
    .req_i   (irq_req),
    .found_o (irq_found),
    .idx_o   (irq_idx)
  );

  intc_irq_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ack_i   (ack),
    .found_i (irq_found),
    .idx_i   (irq_idx),
    .sel_o   (sel)
  );

  assign irq_vec = sel.vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fiq_q <= 1'b0;
    else         fiq_q <= |fiq_req;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_ACTIVE) begin
      rdata_o[VEC_W:0] = {sel.valid, sel.vec};
    end else if (steer_hit) begin
      rdata_o[0] = steer_q[steer_idx];
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (addr_i == A_MASK + ADDR_W'(b) || addr_i == A_MSET + ADDR_W'(b) ||
            addr_i == A_MCLR + ADDR_W'(b)) begin
          rdata_o[BW-1:0] = mask_all[b*BW +: BW];
        end
      end
    end
  end

  assign irq_o = sel.valid;
  assign fiq_o = fiq_q;
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_i,
  input logic               cand_found_i,
  input logic [NUM_SRC-1:0] steer_i
);
  logic ack;
  logic [NUM_SRC-1:0] steer_d;

  assign ack = we_i && (addr_i == A_CTRL) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) steer_d <= '0;
    else         steer_d <= steer_i;
  end

  AST_ACK_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !irq_o); // R8
  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack) |=> (irq_o && $stable(vec_i))); // R7
  AST_RISE_NEEDS_CAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cand_found_i)); // R5
  AST_VEC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int'(vec_i) < NUM_SRC)); // R5
  AST_NO_FAST_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !steer_d[vec_i]); // R9
  AST_IDLE_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_i == VEC_NONE)); // R10
endmodule

bind banked_intc intc_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .irq_o        (irq_o),
  .vec_i        (irq_vec),
  .cand_found_i (irq_found),
  .steer_i      (steer_q)
);

// File: tb/sim_banked_intc.sv
`timescale 1ns/1ps
module sim_banked_intc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [95:0] src_i = '0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [95:0] m_mask  = '1;
  logic [95:0] m_steer = '0;
  logic        m_valid = 1'b0;
  logic [6:0]  m_vec   = 7'h7F;
  logic        m_fiq   = 1'b0;

  always #2 clk_i = ~clk_i;

  banked_intc u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] lowest(input logic [95:0] s);
    logic [6:0] r = 7'h7F;
    for (int i = 95; i >= 0; i--) if (s[i] && !m_mask[i] && !m_steer[i]) r = 7'(i);
    return r;
  endfunction

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    if (a == 8'h01) return {24'h0, m_valid, m_vec};
    if (a >= 8'h80 && a < 8'hE0) return {31'h0, m_steer[a - 8'h80]};
    for (int b = 0; b < 3; b++)
      if (a == 8'h10 + 8'(b) || a == 8'h14 + 8'(b) || a == 8'h18 + 8'(b)) return m_mask[b*32 +: 32];
    return 32'h0;
  endfunction

  function automatic string tag_for(input logic [7:0] a);
    if (a == 8'h01) return "R5/R10 active";
    if (a >= 8'h80) return "R9 steer";
    if (a >= 8'h18) return "R4 clear";
    if (a >= 8'h14) return "R3 set";
    return "R2 mask";
  endfunction

  // one bus cycle: drive, check read pre-edge, advance model, check lines post-edge
  task automatic step(input logic [95:0] s, input bit w, input logic [7:0] a,
                      input logic [31:0] d, output logic [31:0] rd);
    logic [6:0] c;
    @(negedge clk_i);
    src_i = s; we_i = w; addr_i = a; wdata_i = d;
    #1;
    rd = rdata_o;
    if (!w) chk(rdata_o == model_rd(a), tag_for(a), rdata_o, model_rd(a));
    c = lowest(s);
    m_fiq = |(s & ~m_mask & m_steer);
    if (w && a == 8'h00 && d[0]) begin
      m_valid = 1'b0; m_vec = 7'h7F;
    end else if (!m_valid && c != 7'h7F) begin
      m_valid = 1'b1; m_vec = c;
    end
    if (w) begin
      for (int b = 0; b < 3; b++) begin
        if (a == 8'h10 + 8'(b)) m_mask[b*32 +: 32] = d;
        if (a == 8'h14 + 8'(b)) m_mask[b*32 +: 32] = m_mask[b*32 +: 32] | d;
        if (a == 8'h18 + 8'(b)) m_mask[b*32 +: 32] = m_mask[b*32 +: 32] & ~d;
      end
      if (a >= 8'h80 && a < 8'hE0) m_steer[a - 8'h80] = d[0];
    end
    @(posedge clk_i);
    #1;
    chk(irq_o == m_valid, "R7 irq", {31'h0, irq_o}, {31'h0, m_valid});
    chk(fiq_o == m_fiq, "R9 fiq", {31'h0, fiq_o}, {31'h0, m_fiq});
  endtask

  function automatic logic [95:0] bit96(input int i);
    return 96'h1 << i;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [95:0] s;
    void'($urandom(32'h5EED_1234));
    #7 rst_ni = 1'b1;
    #1;
    chk(irq_o == 1'b0 && fiq_o == 1'b0, "R1 lines", {30'h0, irq_o, fiq_o}, 32'h0);
    step('0, 0, 8'h10, 0, r); chk(r == 32'hFFFFFFFF, "R1 bank0", r, 32'hFFFFFFFF);
    step('0, 0, 8'h12, 0, r); chk(r == 32'hFFFFFFFF, "R1 bank2", r, 32'hFFFFFFFF);
    step('0, 0, 8'hC0, 0, r); chk(r == 32'h0, "R1 steer", r, 32'h0);
    step('0, 0, 8'h01, 0, r); chk(r == 32'h7F, "R10 idle", r, 32'h7F);
    // masked source ignored
    step(bit96(40), 0, 8'h11, 0, r);
    chk(irq_o == 1'b0, "R11 masked", {31'h0, irq_o}, 32'h0);
    step(bit96(40), 1, 8'h19, 32'h100, r);
    step(bit96(40), 0, 8'h11, 0, r); chk(r == 32'hFFFFFEFF, "R4 clear", r, 32'hFFFFFEFF);
    chk(irq_o == 1'b1, "R5 raise", {31'h0, irq_o}, 32'h1);
    step(bit96(40), 0, 8'h01, 0, r); chk(r == 32'hA8, "R5 vector", r, 32'hA8);
    // unmask 3 while 40 held, then release
    step(bit96(40) | bit96(3), 1, 8'h18, 32'h8, r);
    step(bit96(40) | bit96(3), 0, 8'h01, 0, r); chk(r == 32'hA8, "R7 held", r, 32'hA8);
    step(bit96(40) | bit96(3), 1, 8'h00, 32'h1, r);
    chk(irq_o == 1'b0, "R8 gap", {31'h0, irq_o}, 32'h0);
    step(bit96(40) | bit96(3), 0, 8'h01, 0, r); chk(r == 32'h7F, "R8 reserved", r, 32'h7F);
    chk(irq_o == 1'b1, "R8 rearb", {31'h0, irq_o}, 32'h1);
    step(bit96(40) | bit96(3), 0, 8'h01, 0, r); chk(r == 32'h83, "R6 lowest", r, 32'h83);
    // drop and mask the held source: vector stays
    step('0, 1, 8'h14, 32'h8, r);
    chk(irq_o == 1'b1, "R7 hold", {31'h0, irq_o}, 32'h1);
    step('0, 0, 8'h01, 0, r); chk(r == 32'h83, "R7 vec", r, 32'h83);
    step('0, 0, 8'h10, 0, r); chk(r == 32'hFFFFFFFF, "R3 set", r, 32'hFFFFFFFF);
    step('0, 1, 8'h15, 32'h0, r);
    step('0, 0, 8'h11, 0, r); chk(r == 32'hFFFFFEFF, "R3 zeros", r, 32'hFFFFFEFF);
    step('0, 1, 8'h12, 32'hFFFF0000, r);
    step('0, 0, 8'h12, 0, r); chk(r == 32'hFFFF0000, "R2 write", r, 32'hFFFF0000);
    step('0, 1, 8'h00, 32'h1, r);
    // fast steering of source 64
    step('0, 1, 8'hC0, 32'h1, r);
    step(bit96(64), 0, 8'hC0, 0, r); chk(r == 32'h1, "R9 steer rd", r, 32'h1);
    chk(fiq_o == 1'b1 && irq_o == 1'b0, "R9 fast", {30'h0, irq_o, fiq_o}, 32'h1);
    step(bit96(64), 0, 8'h01, 0, r); chk(r == 32'h7F, "R9 no vec", r, 32'h7F);
    step(bit96(64), 1, 8'h14 + 8'd2, 32'h1, r);
    step(bit96(64), 0, 8'h01, 0, r);
    chk(fiq_o == 1'b0, "R11 fast masked", {31'h0, fiq_o}, 32'h0);

    // random phase
    s = '0;
    for (int k = 0; k < 4000; k++) begin
      int kind;
      logic [7:0]  a;
      logic [31:0] d;
      bit w;
      if ($urandom % 3 == 0)
        s = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      kind = $urandom % 8;
      d = $urandom & $urandom;
      w = 1'b1;
      case (kind)
        0: begin a = 8'h00; d = 32'h1; end
        1: a = 8'h10 + 8'($urandom % 3);
        2: a = 8'h14 + 8'($urandom % 3);
        3: a = 8'h18 + 8'($urandom % 3);
        4: a = 8'h80 + 8'($urandom % 96);
        5: begin a = 8'h01; w = 1'b0; end
        6: begin a = 8'h10 + 8'($urandom % 3); w = 1'b0; end
        default: begin a = 8'h80 + 8'($urandom % 96); w = 1'b0; end
      endcase
      step(s, w, a, d, r);
    end
    finish_run();
  end
endmodule